// File: doc/BRIEF.md
# T=1 Block Check Unit

This unit adds and verifies the error-detection field of T=1 block-protocol transfers. The transmit path takes a byte stream from the host and passes each byte through. When the host flags the final byte of a block, the unit appends the check field to the outgoing stream: one byte of longitudinal XOR, or two bytes of a 16-bit CRC. The receive path takes the byte stream arriving from the card. It forwards the first `rx_len` bytes of each block, consumes the check field that follows them, and reports once per block whether that field matched what it computed itself.

Both paths use byte-wide valid/ready streams. A byte moves only in a cycle where valid and ready are both high. A source that raises valid keeps valid, data and the last flag unchanged until the byte is taken. While a data byte passes through, each path drives its input ready from its output ready, so back-pressure reaches the source in the same cycle. While the transmit path emits check bytes it holds its input ready low. While the receive path consumes check bytes it holds its input ready high. Both paths share the host controls `cfg_en` and `cfg_crc`. Each path samples these controls, together with `rx_len` on the receive side, on the first byte of a block and keeps them for the rest of that block. With `cfg_en` low, both paths become plain pipes.

Top module: `edc_unit`

## Requirements
- R1: With checking enabled, every byte accepted on the transmit input leaves the transmit output unchanged and in order. `tx_m_last` stays low on data bytes.
- R2: With `cfg_crc`=0, the transmit path emits exactly one check byte after the byte flagged by `tx_s_last`. That byte is the XOR of all data bytes of the block, and `tx_m_last` is high on it.
- R3: With `cfg_crc`=1, the transmit path emits two check bytes, most significant byte first, with `tx_m_last` high only on the second. The CRC uses polynomial 0x1021 and starts from 0xFFFF. Each byte is shifted in most significant bit first, and the result is not inverted at the end.
- R4: While check bytes are pending, `tx_s_ready` is low. Each new block starts from a fresh accumulator.
- R5: With `cfg_en`=0, both paths pass bytes through unchanged and insert or strip nothing. `tx_m_last` follows `tx_s_last`. `rx_m_last` marks the `rx_len`-th byte. `rx_done` stays low and `rx_ok` keeps its value.
- R6: With checking enabled, the receive path forwards the first `rx_len` bytes of a block, with `rx_m_last` high on the last of them. It then takes the 1 or 2 check bytes with `rx_s_ready` high and does not forward them.
- R7: `rx_done` is high for one cycle, in the cycle after the handshake of the final check byte. From that cycle until the next `rx_done`, `rx_ok` is 1 if every check byte matched and 0 otherwise.
- R8: Changes to `cfg_en`, `cfg_crc` or `rx_len` after the first byte of a block has been accepted do not affect that block.
- R9: An `rx_len` of 0 makes a receive block consist only of its check field. The empty-block values are 0x00 for the XOR byte and 0xFFFF for the CRC.
- R10: After reset, `tx_m_valid`, `rx_m_valid`, `rx_done` and `rx_ok` are low.
- R11: While an output stalls (valid high, ready low), the next cycle still shows valid high with the same data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en | input | 1 | 1: generate and verify check fields; 0: pass-through |
| cfg_crc | input | 1 | 0: one-byte XOR check; 1: two-byte CRC |
| rx_len | input | LEN_W | Data bytes in the next receive block |
| tx_s_valid | input | 1 | Transmit input byte valid |
| tx_s_ready | output | 1 | Transmit input ready |
| tx_s_data | input | 8 | Transmit input byte |
| tx_s_last | input | 1 | Final data byte of the transmit block |
| tx_m_valid | output | 1 | Transmit output byte valid |
| tx_m_ready | input | 1 | Transmit output ready |
| tx_m_data | output | 8 | Transmit output byte |
| tx_m_last | output | 1 | Final byte of the outgoing block |
| rx_s_valid | input | 1 | Receive input byte valid |
| rx_s_ready | output | 1 | Receive input ready |
| rx_s_data | input | 8 | Receive input byte |
| rx_m_valid | output | 1 | Forwarded data byte valid |
| rx_m_ready | input | 1 | Forwarded data ready |
| rx_m_data | output | 8 | Forwarded data byte |
| rx_m_last | output | 1 | Final forwarded byte of the block |
| rx_done | output | 1 | One-cycle pulse when a block's check field has been consumed |
| rx_ok | output | 1 | Result of the most recent check |

## Verification
A corrupted accumulator does not show up while data is passing. It shows up only at the end of a block. On transmit, the check byte or bytes come out wrong within a cycle of the byte flagged last. On receive, the bad value appears as a false `rx_ok` on the `rx_done` pulse that follows the final check byte. A wrong byte counter or phase register shows up sooner, as `rx_m_last` on the wrong byte, a check byte forwarded to the output, or a ready held in the wrong state. Blocks of every length up to two dozen bytes, in both modes, with random stalls on both sides, reach each of these outcomes within a few cycles of the fault.

// File: rtl/edc_pkg.sv
package edc_pkg;

  typedef enum logic [1:0] {
    TX_PASS = 2'd0,
    TX_CK_A = 2'd1,
    TX_CK_B = 2'd2
  } tx_phase_t;

  typedef struct packed {
    logic en;
    logic crc;
  } chk_cfg_t;

endpackage

// File: rtl/edc_accum.sv
module edc_accum #(
  parameter int            DW   = 8,
  parameter int            CW   = 16,
  parameter logic [CW-1:0] POLY = 16'h1021,
  parameter logic [CW-1:0] SEED = 16'hFFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          upd,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] lrc,
  output logic [CW-1:0] crc
);

  logic [DW-1:0] lrc_q;
  logic [CW-1:0] crc_q;
  logic [CW-1:0] crc_nx;

  // Shift the byte into the CRC one bit at a time, MSB first.
  always_comb begin
    logic fb;
    crc_nx = crc_q;
    for (int b = DW - 1; b >= 0; b--) begin
      fb     = crc_nx[CW-1] ^ din[b];
      crc_nx = {crc_nx[CW-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lrc_q <= '0;
      crc_q <= SEED;
    end else if (clr) begin
      lrc_q <= '0;
      crc_q <= SEED;
    end else if (upd) begin
      lrc_q <= lrc_q ^ din;
      crc_q <= crc_nx;
    end
  end

  assign lrc = lrc_q;
  assign crc = crc_q;

endmodule

// File: rtl/edc_tx.sv
module edc_tx
  import edc_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_en,
  input  logic          cfg_crc,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  input  logic          s_last,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [DW-1:0] m_data,
  output logic          m_last
);

  tx_phase_t     ph_q;
  logic          busy_q;
  chk_cfg_t      cfg_q;
  chk_cfg_t      cfg_live;
  chk_cfg_t      cfg_e;
  logic [DW-1:0] lrc;
  logic [CW-1:0] crc;
  logic          s_fire;
  logic          m_fire;
  logic          acc_upd;
  logic          acc_clr;

  assign cfg_live.en  = cfg_en;
  assign cfg_live.crc = cfg_crc;
  // Configuration is frozen from the first byte of a block onward.
  assign cfg_e        = busy_q ? cfg_q : cfg_live;

  always_comb begin
    s_ready = 1'b0;
    m_valid = 1'b0;
    m_data  = s_data;
    m_last  = 1'b0;
    case (ph_q)
      TX_PASS: begin
        s_ready = m_ready;
        m_valid = s_valid;
        m_data  = s_data;
        m_last  = s_last && !cfg_e.en;
      end
      TX_CK_A: begin
        m_valid = 1'b1;
        m_data  = cfg_q.crc ? crc[CW-1:CW-DW] : lrc;
        m_last  = !cfg_q.crc;
      end
      TX_CK_B: begin
        m_valid = 1'b1;
        m_data  = crc[DW-1:0];
        m_last  = 1'b1;
      end
      default: ;
    endcase
  end

  assign s_fire  = s_valid && s_ready;
  assign m_fire  = m_valid && m_ready;
  assign acc_upd = (ph_q == TX_PASS) && s_fire && cfg_e.en;
  assign acc_clr = m_fire && (((ph_q == TX_CK_A) && !cfg_q.crc) || (ph_q == TX_CK_B));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= TX_PASS;
      busy_q <= 1'b0;
      cfg_q  <= '0;
    end else begin
      case (ph_q)
        TX_PASS: begin
          if (s_fire) begin
            if (!busy_q) cfg_q <= cfg_live;
            if (s_last) begin
              busy_q <= cfg_e.en;
              if (cfg_e.en) ph_q <= TX_CK_A;
            end else begin
              busy_q <= 1'b1;
            end
          end
        end
        TX_CK_A: begin
          if (m_fire) begin
            if (cfg_q.crc) begin
              ph_q <= TX_CK_B;
            end else begin
              ph_q   <= TX_PASS;
              busy_q <= 1'b0;
            end
          end
        end
        TX_CK_B: begin
          if (m_fire) begin
            ph_q   <= TX_PASS;
            busy_q <= 1'b0;
          end
        end
        default: ph_q <= TX_PASS;
      endcase
    end
  end

  edc_accum #(.DW(DW), .CW(CW)) u_acc (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (acc_clr),
    .upd  (acc_upd),
    .din  (s_data),
    .lrc  (lrc),
    .crc  (crc)
  );

endmodule

// File: rtl/edc_rx.sv
module edc_rx
  import edc_pkg::*;
#(
  parameter int DW    = 8,
  parameter int CW    = 16,
  parameter int LEN_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_crc,
  input  logic [LEN_W-1:0] rx_len,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [DW-1:0]    s_data,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [DW-1:0]    m_data,
  output logic             m_last,
  output logic             done,
  output logic             ok
);

  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] len_e;
  logic [LEN_W:0]   cnt_inc;
  logic             busy_q;
  logic             ck_q;
  logic             mis_q;
  logic             done_q;
  logic             ok_q;
  chk_cfg_t         cfg_q;
  chk_cfg_t         cfg_live;
  chk_cfg_t         cfg_e;
  logic             data_ph;
  logic             byp_end;
  logic             s_fire;
  logic [DW-1:0]    exp_byte;
  logic             byte_bad;
  logic             last_ck;
  logic             acc_upd;
  logic             acc_clr;
  logic [DW-1:0]    lrc;
  logic [CW-1:0]    crc;

  assign cfg_live.en  = cfg_en;
  assign cfg_live.crc = cfg_crc;
  assign cfg_e        = busy_q ? cfg_q : cfg_live;
  assign len_e        = busy_q ? len_q : rx_len;
  assign cnt_inc      = {1'b0, cnt_q} + 1'b1;

  // Data phase until rx_len bytes have gone by; always data in bypass.
  assign data_ph = !cfg_e.en || (cnt_q != len_e);
  assign byp_end = cnt_inc >= {1'b0, len_e};

  assign m_valid = data_ph && s_valid;
  assign s_ready = data_ph ? m_ready : 1'b1;
  assign m_data  = s_data;
  assign m_last  = cfg_e.en ? (cnt_inc == {1'b0, len_e}) : byp_end;

  assign exp_byte = ck_q ? crc[DW-1:0] : (cfg_e.crc ? crc[CW-1:CW-DW] : lrc);
  assign byte_bad = s_data != exp_byte;
  assign last_ck  = !cfg_e.crc || ck_q;
  assign s_fire   = s_valid && s_ready;
  assign acc_upd  = s_fire && data_ph && cfg_e.en;
  assign acc_clr  = s_fire && !data_ph && last_ck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      len_q  <= '0;
      busy_q <= 1'b0;
      ck_q   <= 1'b0;
      mis_q  <= 1'b0;
      done_q <= 1'b0;
      ok_q   <= 1'b0;
      cfg_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (s_fire) begin
        if (!busy_q) begin
          cfg_q <= cfg_live;
          len_q <= rx_len;
        end
        if (data_ph) begin
          if (!cfg_e.en && byp_end) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
          end else begin
            cnt_q  <= cnt_q + 1'b1;
            busy_q <= 1'b1;
          end
        end else if (last_ck) begin
          cnt_q  <= '0;
          ck_q   <= 1'b0;
          mis_q  <= 1'b0;
          busy_q <= 1'b0;
          done_q <= 1'b1;
          ok_q   <= !(mis_q || byte_bad);
        end else begin
          ck_q   <= 1'b1;
          mis_q  <= byte_bad;
          busy_q <= 1'b1;
        end
      end
    end
  end

  assign done = done_q;
  assign ok   = ok_q;

  edc_accum #(.DW(DW), .CW(CW)) u_acc (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (acc_clr),
    .upd  (acc_upd),
    .din  (s_data),
    .lrc  (lrc),
    .crc  (crc)
  );

endmodule

// File: rtl/edc_unit.sv
module edc_unit #(
  parameter int LEN_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_crc,
  input  logic [LEN_W-1:0] rx_len,
  input  logic             tx_s_valid,
  output logic             tx_s_ready,
  input  logic [7:0]       tx_s_data,
  input  logic             tx_s_last,
  output logic             tx_m_valid,
  input  logic             tx_m_ready,
  output logic [7:0]       tx_m_data,
  output logic             tx_m_last,
  input  logic             rx_s_valid,
  output logic             rx_s_ready,
  input  logic [7:0]       rx_s_data,
  output logic             rx_m_valid,
  input  logic             rx_m_ready,
  output logic [7:0]       rx_m_data,
  output logic             rx_m_last,
  output logic             rx_done,
  output logic             rx_ok
);

  localparam int DW = 8;
  localparam int CW = 2 * DW;

  edc_tx #(.DW(DW), .CW(CW)) u_tx (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg_en (cfg_en),
    .cfg_crc(cfg_crc),
    .s_valid(tx_s_valid),
    .s_ready(tx_s_ready),
    .s_data (tx_s_data),
    .s_last (tx_s_last),
    .m_valid(tx_m_valid),
    .m_ready(tx_m_ready),
    .m_data (tx_m_data),
    .m_last (tx_m_last)
  );

  edc_rx #(.DW(DW), .CW(CW), .LEN_W(LEN_W)) u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg_en (cfg_en),
    .cfg_crc(cfg_crc),
    .rx_len (rx_len),
    .s_valid(rx_s_valid),
    .s_ready(rx_s_ready),
    .s_data (rx_s_data),
    .m_valid(rx_m_valid),
    .m_ready(rx_m_ready),
    .m_data (rx_m_data),
    .m_last (rx_m_last),
    .done   (rx_done),
    .ok     (rx_ok)
  );

endmodule

// File: rtl/edc_unit_chk.sv
module edc_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_s_ready,
  input logic       tx_m_valid,
  input logic       tx_m_ready,
  input logic [7:0] tx_m_data,
  input logic       tx_m_last,
  input logic       rx_s_valid,
  input logic       rx_s_ready,
  input logic       rx_m_valid,
  input logic       rx_m_ready,
  input logic       rx_done,
  input logic       rx_ok
);

  // R11
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_m_valid && !tx_m_ready |=> tx_m_valid && $stable(tx_m_data) && $stable(tx_m_last));

  // R4
  tx_ck_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_s_ready && tx_m_ready |-> tx_m_valid);

  // R6
  rx_fwd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_m_valid |-> rx_s_valid);

  // R7
  rx_done_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> $past(rx_s_valid && rx_s_ready));

  // R6
  rx_ck_not_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> !$past(rx_m_valid && rx_m_ready));

  // R7
  rx_ok_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_done |-> $stable(rx_ok));

endmodule

bind edc_unit edc_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_s_ready(tx_s_ready),
  .tx_m_valid(tx_m_valid),
  .tx_m_ready(tx_m_ready),
  .tx_m_data (tx_m_data),
  .tx_m_last (tx_m_last),
  .rx_s_valid(rx_s_valid),
  .rx_s_ready(rx_s_ready),
  .rx_m_valid(rx_m_valid),
  .rx_m_ready(rx_m_ready),
  .rx_done   (rx_done),
  .rx_ok     (rx_ok)
);

// File: tb/edc_unit_tb.sv
`timescale 1ns/1ps
module edc_unit_tb;

  localparam int LEN_W = 9;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_en = 1'b1;
  logic             cfg_crc = 1'b0;
  logic [LEN_W-1:0] rx_len = '0;
  logic             tx_s_valid = 1'b0;
  logic             tx_s_ready;
  logic [7:0]       tx_s_data = '0;
  logic             tx_s_last = 1'b0;
  logic             tx_m_valid;
  logic             tx_m_ready = 1'b0;
  logic [7:0]       tx_m_data;
  logic             tx_m_last;
  logic             rx_s_valid = 1'b0;
  logic             rx_s_ready;
  logic [7:0]       rx_s_data = '0;
  logic             rx_m_valid;
  logic             rx_m_ready = 1'b0;
  logic [7:0]       rx_m_data;
  logic             rx_m_last;
  logic             rx_done;
  logic             rx_ok;

  int          n_chk = 0;
  int          n_bad = 0;
  logic [15:0] rng = 16'hACE1;

  always #4 clk = ~clk;

  edc_unit #(.LEN_W(LEN_W)) u_dut (.*);

  task automatic chk(input bit cond, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  function automatic bit rbit();
    rng = {rng[14:0], rng[15] ^ rng[13] ^ rng[12] ^ rng[10]};
    return rng[0] | rng[3];
  endfunction

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int b = 7; b >= 0; b--) begin
      if (r[15] ^ d[b]) r = (r << 1) ^ 16'h1021;
      else r = r << 1;
    end
    return r;
  endfunction

  function automatic logic [7:0] gen(input int i, input int len, input int seed);
    return 8'((i * 29 + len * 7 + seed * 13 + 5) & 255);
  endfunction

  // Transmit one block and compare the output stream against the expected bytes.
  task automatic run_tx(input int len, input bit kind, input bit en, input int flip_at, input int seed);
    logic [7:0] dat [0:63];
    logic [7:0] ex [0:63];
    bit         exl [0:63];
    int nx, idx, got, cyc;
    bit ok, hold_ok, offer, pstall;
    logic [7:0] lrc, pdat;
    logic [15:0] crc;
    lrc = 8'h00; crc = 16'hFFFF;
    for (int i = 0; i < len; i++) begin
      dat[i] = gen(i, len, seed);
      ex[i] = dat[i]; exl[i] = !en && (i == len - 1);
      lrc ^= dat[i]; crc = crc_step(crc, dat[i]);
    end
    nx = len;
    if (en) begin
      if (kind) begin
        ex[nx] = crc[15:8]; exl[nx] = 1'b0; nx++;
        ex[nx] = crc[7:0];  exl[nx] = 1'b1; nx++;
      end else begin
        ex[nx] = lrc; exl[nx] = 1'b1; nx++;
      end
    end
    @(negedge clk);
    cfg_en = en; cfg_crc = kind;
    idx = 0; got = 0; cyc = 0; ok = 1; hold_ok = 1; offer = 0; pstall = 0; pdat = 0;
    while (got < nx && cyc < 2000) begin
      @(negedge clk); cyc++;
      tx_m_ready = rbit();
      if (!offer && idx < len && rbit()) offer = 1;
      tx_s_valid = offer;
      tx_s_data  = (idx < len) ? dat[idx] : 8'h00;
      tx_s_last  = (idx == len - 1);
      if (idx == flip_at && flip_at > 0) begin cfg_crc = !kind; cfg_en = !en; end
      #2;
      if (pstall && !(tx_m_valid && tx_m_data == pdat)) hold_ok = 0;
      pstall = tx_m_valid && !tx_m_ready; pdat = tx_m_data;
      if (tx_m_valid && tx_m_ready) begin
        if (got >= nx || tx_m_data != ex[got] || tx_m_last != exl[got]) begin
          if (ok) $display("FAIL %s tx block len %0d byte %0d: actual 0x%0h/%0b expected 0x%0h/%0b",
                           flip_at > 0 ? "R8" : (!en ? "R5" : (kind ? "R3" : "R2")),
                           len, got, tx_m_data, tx_m_last, ex[got], exl[got]);
          ok = 0;
        end
        got++;
      end
      if (tx_s_valid && tx_s_ready) begin idx++; offer = 0; end
    end
    @(negedge clk);
    tx_s_valid = 0; tx_s_last = 0; cfg_en = en; cfg_crc = kind;
    // R1 R2 R3 R4 R5 R8: whole block and check field as expected
    n_chk++;
    if (!ok || got != nx) begin
      n_bad++;
      if (ok) $display("FAIL R1 tx block len %0d count: actual %0d expected %0d", len, got, nx);
    end
    chk(hold_ok, "R11", "tx output hold", 0, 1);
  endtask

  // Receive one block; corrupt >= 0 flips bit 0 of that stream byte.
  task automatic run_rx(input int len, input bit kind, input bit en, input int corrupt, input int flip_at, input int seed);
    logic [7:0] st [0:63];
    int ns, idx, got, cyc, tail, dones;
    bit ok, offer, okv, ok0;
    logic [7:0] lrc;
    logic [15:0] crc;
    lrc = 8'h00; crc = 16'hFFFF;
    for (int i = 0; i < len; i++) begin
      st[i] = gen(i, len, seed);
      lrc ^= st[i]; crc = crc_step(crc, st[i]);
    end
    ns = len;
    if (en) begin
      if (kind) begin st[ns] = crc[15:8]; st[ns+1] = crc[7:0]; ns += 2; end
      else begin st[ns] = lrc; ns++; end
    end
    if (corrupt >= 0) st[corrupt] ^= 8'h01;
    @(negedge clk);
    cfg_en = en; cfg_crc = kind; rx_len = LEN_W'(len);
    ok0 = rx_ok;
    idx = 0; got = 0; cyc = 0; tail = 0; dones = 0; ok = 1; offer = 0; okv = 0;
    while ((idx < ns || tail < 4) && cyc < 2000) begin
      @(negedge clk); cyc++;
      rx_m_ready = rbit();
      if (!offer && idx < ns && rbit()) offer = 1;
      rx_s_valid = offer;
      rx_s_data  = (idx < ns) ? st[idx] : 8'h00;
      if (idx == flip_at && flip_at > 0) begin rx_len = LEN_W'(len + 5); cfg_crc = !kind; cfg_en = !en; end
      #2;
      if (rx_m_valid && rx_m_ready) begin
        if (got >= len || rx_m_data != st[got] || rx_m_last != (got == len - 1)) begin
          if (ok) $display("FAIL %s rx block len %0d byte %0d: actual 0x%0h/%0b expected 0x%0h/%0b",
                           flip_at > 0 ? "R8" : (en ? "R6" : "R5"), len, got, rx_m_data, rx_m_last,
                           (got < len) ? st[got] : 8'h00, got == len - 1);
          ok = 0;
        end
        got++;
      end
      if (rx_done) begin dones++; okv = rx_ok; end
      if (rx_s_valid && rx_s_ready) begin idx++; offer = 0; end
      if (idx >= ns) tail++;
    end
    @(negedge clk);
    rx_s_valid = 0; cfg_en = en; cfg_crc = kind; rx_len = LEN_W'(len);
    // R6 R9 (and R5 in bypass): forwarded bytes
    n_chk++;
    if (!ok || got != len) begin
      n_bad++;
      if (ok) $display("FAIL R6 rx block len %0d forwarded: actual %0d expected %0d", len, got, len);
    end
    if (en) begin
      chk(dones == 1, "R7", "rx_done pulses", dones, 1);
      chk(okv == (corrupt < 0), len == 0 ? "R9" : "R7", "rx_ok at done", okv, corrupt < 0);
      chk(rx_ok == (corrupt < 0), "R7", "rx_ok held", rx_ok, corrupt < 0);
    end else begin
      chk(dones == 0, "R5", "rx_done in bypass", dones, 0);
      chk(rx_ok == ok0, "R5", "rx_ok in bypass", rx_ok, ok0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] c;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!tx_m_valid && !rx_m_valid && !rx_done && !rx_ok, "R10", "outputs in reset",
        {tx_m_valid, rx_m_valid, rx_done, rx_ok}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tx_m_valid && !rx_m_valid && !rx_done && !rx_ok, "R10", "outputs after reset",
        {tx_m_valid, rx_m_valid, rx_done, rx_ok}, 0);

    // R3: the bench CRC against the well-known nine-digit check value
    c = 16'hFFFF;
    for (int i = 0; i < 9; i++) c = crc_step(c, 8'(8'h31 + i));
    chk(c == 16'h29B1, "R3", "bench crc reference", c, 16'h29B1);

    // R1 R2 R3 R4: transmit sweep over lengths and both check types
    for (int len = 1; len <= 24; len++) begin
      run_tx(len, 1'b0, 1'b1, -1, len);
      run_tx(len, 1'b1, 1'b1, -1, len + 3);
    end
    // R5: transmit bypass
    for (int len = 1; len <= 6; len++) run_tx(len, len[0], 1'b0, -1, 9);
    // R8: configuration flipped mid-block
    run_tx(7, 1'b1, 1'b1, 3, 2);
    run_tx(5, 1'b0, 1'b1, 2, 4);

    // R6 R7 R9: receive sweep, clean and corrupted
    for (int len = 0; len <= 24; len++) begin
      run_rx(len, 1'b0, 1'b1, -1, -1, len);
      run_rx(len, 1'b1, 1'b1, -1, -1, len + 1);
      run_rx(len, 1'b0, 1'b1, len, -1, len + 2);
      run_rx(len, 1'b1, 1'b1, (len * 5) % (len + 2), -1, len + 3);
    end
    // R5: receive bypass after both clean and failed results
    run_rx(4, 1'b0, 1'b1, 1, -1, 1);
    run_rx(6, 1'b1, 1'b0, -1, -1, 2);
    run_rx(3, 1'b0, 1'b1, -1, -1, 3);
    run_rx(5, 1'b0, 1'b0, -1, -1, 4);
    // R8: receive configuration flipped mid-block
    run_rx(6, 1'b1, 1'b1, -1, 2, 5);
    run_rx(4, 1'b0, 1'b1, -1, 1, 6);

    summary();
  end

endmodule